// File: doc/BRIEF.md
# Seeded Random Word Generator Peripheral

This block is a 32-bit register-mapped random word source that software drives by polling. It occupies a 512-byte window. Software writes five seed words, selects the generator engine and requests a run through the control register. It then polls the status register until the done flag is set and reads five fresh output words. A 5-bit mask records which seed words have been written. No run starts until all five are present.

The generator keeps a 160-bit state made of five 32-bit words. Each seed write loads one of those words. A run takes five cycles. In each cycle the state takes one xorshift step and one output word is produced. The state carries over from run to run, so a later run continues the same sequence unless new seeds are written.

Top module: `prng_mmio`

## Requirements
- R1: After reset the control register reads 0x00000000, the status register reads 0x00000001 and all five output words read 0.
- R2: Reads return data on `rd_data_o` one cycle after `rd_en_i` and 0 in cycles with no read. The map is: control at 0x000, status at 0x010, output word n at 0x160+4n. All other offsets read 0, including the seed words (write-only at 0x140+4n) and any unaligned address.
- R3: A write to seed word n sets bit n of the seed mask. Status bit 1 reads 1 exactly when all five mask bits are set. Only reset clears the mask.
- R4: A control write starts a run only when all of these hold: status bit 1 is set, written bit 3 (engine select) is 1, written bit 4 (start) is 1, and no run is in progress. Otherwise the output words and status bit 5 are left unchanged.
- R5: A control write stores the written value with bit 4 forced to 0, whether or not a run starts.
- R6: A run holds status bit 2 (busy) high for exactly five cycles and then sets status bit 5 (done). A control write received during a run is stored but does not start a second run.
- R7: A status write loads bits 5, 4 and 3 from the written data and leaves every other status bit unchanged. Bit 7 always reads 0 and bit 0 always reads 1. If a run completes in the same cycle as a status write, bit 5 ends up set.
- R8: A seed write to word n loads state word s_n, but it is dropped while a run is in progress. Each step computes t = s0 ^ (s0 << 11), then t ^= t >> 8, then new = s4 ^ (s4 >> 19) ^ t. It then shifts the state so that s0..s3 take s1..s4 and s4 takes new. Output word k receives the new word from step k, where k runs from 0 to 4.
- R9: If the 160-bit state is all zero when a run starts, it is first replaced by s_k = 0x9E3779B9 + k*0x7F4A7C15 (mod 2^32).
- R10: Writes to unmapped or unaligned offsets, and writes to the output words, change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Byte offset within the window |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |

## Verification
The hardest cases to reach are the collisions inside the five-cycle run. These are a control write with start set arriving while busy, a seed write that must be dropped mid-run, and a status write that clears the done flag on the same edge that the run sets it. The bench reaches each of them by timing its bus tasks to the exact cycle after the start write. It then confirms the outcome through the busy duration, the status value and the five output words, which are computed from the stated step rule. An all-zero seed set drives the constant-fill path. A random mix of seed, control, status and arbitrary-address accesses covers the decode.

// File: rtl/prng_mmio_pkg.sv
package prng_mmio_pkg;
  parameter int unsigned ADDR_W = 9;

  localparam logic [ADDR_W-1:0] CTRL_OFF  = 9'h000;
  localparam logic [ADDR_W-1:0] STAT_OFF  = 9'h010;
  localparam logic [ADDR_W-1:0] SEED_BASE = 9'h140;
  localparam logic [ADDR_W-1:0] OUT_BASE  = 9'h160;

  localparam int unsigned CTRL_ENG_BIT = 3;
  localparam int unsigned CTRL_GO_BIT  = 4;

  localparam int unsigned ST_ERR  = 7;
  localparam int unsigned ST_DONE = 5;
  localparam int unsigned ST_MSG  = 4;
  localparam int unsigned ST_PART = 3;
  localparam int unsigned ST_BUSY = 2;
  localparam int unsigned ST_SEED = 1;
  localparam int unsigned ST_RDY  = 0;

  localparam int unsigned SH_A = 11;
  localparam int unsigned SH_B = 8;
  localparam int unsigned SH_C = 19;

  localparam logic [31:0] FILL_BASE = 32'h9E3779B9;
  localparam logic [31:0] FILL_STEP = 32'h7F4A7C15;
endpackage

// File: rtl/prng_seed_mask.sv
module prng_seed_mask #(
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_WORDS-1:0] mask_o,
  output logic                 ready_o
);
  logic [NUM_WORDS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (we_i) mask_q[idx_i] <= 1'b1;
  end

  assign mask_o  = mask_q;
  assign ready_o = &mask_q;

  a_r3_mask_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mask_o[$past(idx_i)]);
  a_r3_mask_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(mask_o) & ~mask_o) == '0));
endmodule

// File: rtl/prng_engine.sv
module prng_engine
  import prng_mmio_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS),
  localparam int unsigned CNT_W = $clog2(NUM_WORDS)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic                               seed_we_i,
  input  logic [IDX_W-1:0]                   seed_idx_i,
  input  logic [DATA_W-1:0]                  seed_data_i,
  output logic                               busy_o,
  output logic                               done_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]   out_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

  logic [NUM_WORDS-1:0][DATA_W-1:0] state_q, out_q, fill_w;
  logic                             busy_q;
  logic [CNT_W-1:0]                 cnt_q;
  logic [DATA_W-1:0]                mix_a, mix_b, new_word;

  always_comb begin
    for (int k = 0; k < NUM_WORDS; k++)
      fill_w[k] = DATA_W'(FILL_BASE) + DATA_W'(k) * DATA_W'(FILL_STEP);
  end

  always_comb begin
    mix_a    = state_q[0] ^ (state_q[0] << SH_A);
    mix_b    = mix_a ^ (mix_a >> SH_B);
    new_word = state_q[NUM_WORDS-1] ^ (state_q[NUM_WORDS-1] >> SH_C) ^ mix_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      out_q   <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (busy_q) begin
      for (int i = 0; i < NUM_WORDS - 1; i++) state_q[i] <= state_q[i+1];
      state_q[NUM_WORDS-1] <= new_word;
      out_q[cnt_q]         <= new_word;
      cnt_q                <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      if (state_q == '0) state_q <= fill_w;
    end else if (seed_we_i) begin
      state_q[seed_idx_i] <= seed_data_i;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign out_o  = out_q;

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q <= LAST));
  a_r6_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && cnt_q == '0));
  a_r6_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r8_out_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(out_o));
  a_r9_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (state_q != '0));
endmodule

// File: rtl/prng_mmio.sv
module prng_mmio
  import prng_mmio_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_WORDS);

  logic              aligned, is_ctrl, is_stat, seed_hit, out_hit;
  logic [ADDR_W-1:0] seed_off, out_off;
  logic [IDX_W-1:0]  seed_idx, out_idx;
  logic              wr_ctrl, wr_stat, wr_seed, start;
  logic [DATA_W-1:0] ctrl_q, status_w, rd_val;
  logic [2:0]        flags_q;
  logic              seed_ready, eng_busy, eng_done;
  logic [NUM_WORDS-1:0]              seed_mask;
  logic [NUM_WORDS-1:0][DATA_W-1:0]  out_words;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign is_ctrl  = (addr_i == CTRL_OFF);
  assign is_stat  = (addr_i == STAT_OFF);
  assign seed_off = addr_i - SEED_BASE;
  assign out_off  = addr_i - OUT_BASE;
  assign seed_hit = aligned && (addr_i >= SEED_BASE) && (seed_off < SPAN);
  assign out_hit  = aligned && (addr_i >= OUT_BASE) && (out_off < SPAN);
  assign seed_idx = seed_off[IDX_W+1:2];
  assign out_idx  = out_off[IDX_W+1:2];

  assign wr_ctrl = wr_en_i && is_ctrl;
  assign wr_stat = wr_en_i && is_stat;
  assign wr_seed = wr_en_i && seed_hit;
  assign start   = wr_ctrl && seed_ready && wr_data_i[CTRL_ENG_BIT] && wr_data_i[CTRL_GO_BIT];

  prng_seed_mask #(.NUM_WORDS(NUM_WORDS)) u_seed_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_seed),
    .idx_i   (seed_idx),
    .mask_o  (seed_mask),
    .ready_o (seed_ready)
  );

  prng_engine #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .seed_we_i   (wr_seed),
    .seed_idx_i  (seed_idx),
    .seed_data_i (wr_data_i),
    .busy_o      (eng_busy),
    .done_o      (eng_done),
    .out_o       (out_words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q              <= wr_data_i;
      ctrl_q[CTRL_GO_BIT] <= 1'b0;  // start request never persists
    end
  end

  // flags_q = {done, msg, partial}; run completion wins over a status write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else begin
      if (wr_stat) flags_q <= wr_data_i[ST_DONE:ST_PART];
      if (eng_done) flags_q[2] <= 1'b1;
    end
  end

  always_comb begin
    status_w          = '0;
    status_w[ST_ERR]  = 1'b0;
    status_w[ST_DONE] = flags_q[2];
    status_w[ST_MSG]  = flags_q[1];
    status_w[ST_PART] = flags_q[0];
    status_w[ST_BUSY] = eng_busy;
    status_w[ST_SEED] = seed_ready;
    status_w[ST_RDY]  = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    if (is_ctrl)      rd_val = ctrl_q;
    else if (is_stat) rd_val = status_w;
    else if (out_hit) rd_val = out_words[out_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_en_i ? rd_val : '0;
  end

  a_r5_go_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> !ctrl_q[CTRL_GO_BIT]);
  a_r2_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !is_ctrl && !is_stat && !out_hit) |=> (rd_data_o == '0));
  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rd_data_o == '0));
  a_r4_no_start_unready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !seed_ready && !eng_busy) |=> !eng_busy);
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[2] && !wr_stat) |=> flags_q[2]);
  a_r7_done_on_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> flags_q[2]);
endmodule

// File: tb/prng_mmio_bench.sv
module prng_mmio_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;

  prng_mmio u_prng_mmio (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  logic [31:0] m_state [N];
  logic [31:0] m_out   [N];
  logic [31:0] m_ctrl;
  logic [4:0]  m_mask;
  logic [2:0]  m_flags;

  function automatic logic [31:0] step_word(logic [31:0] a, logic [31:0] e);
    logic [31:0] t;
    t = a ^ (a << 11);
    t = t ^ (t >> 8);
    return e ^ (e >> 19) ^ t;
  endfunction

  function automatic logic [31:0] exp_status();
    return {24'h0, 2'b00, m_flags, 1'b0, (m_mask == 5'h1F), 1'b1};
  endfunction

  function automatic logic [31:0] exp_read(logic [8:0] a);
    if (a == 9'h000) return m_ctrl;
    if (a == 9'h010) return exp_status();
    if (a[1:0] == 2'b00 && a >= 9'h160 && a < 9'h174) return m_out[(a - 9'h160) >> 2];
    return 32'h0;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin m_state[i] = '0; m_out[i] = '0; end
    m_ctrl = '0; m_mask = '0; m_flags = '0;
  endfunction

  function automatic void model_run();
    logic [31:0] nw;
    logic        zero;
    zero = 1'b1;
    for (int i = 0; i < N; i++) if (m_state[i] != 0) zero = 1'b0;
    if (zero) for (int i = 0; i < N; i++) m_state[i] = 32'h9E3779B9 + 32'(i) * 32'h7F4A7C15;
    for (int k = 0; k < N; k++) begin
      nw = step_word(m_state[0], m_state[N-1]);
      for (int i = 0; i < N-1; i++) m_state[i] = m_state[i+1];
      m_state[N-1] = nw;
      m_out[k] = nw;
    end
    m_flags[2] = 1'b1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic seed_wr(input int n, input logic [31:0] d);
    bus_wr(9'h140 + 9'(4*n), d);
    m_mask[n] = 1'b1;
    m_state[n] = d;
  endtask

  // control write; returns 1 if the model says a run starts (caller idles)
  task automatic ctrl_wr(input logic [31:0] d, output bit started);
    bus_wr(9'h000, d);
    m_ctrl = d & ~32'h10;
    started = (m_mask == 5'h1F) && d[3] && d[4];
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, exp_read(a));
  endtask

  task automatic chk_all(input string req);
    rd_chk(req, 9'h000);
    rd_chk(req, 9'h010);
    for (int i = 0; i < N; i++) rd_chk(req, 9'h160 + 9'(4*i));
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    model_reset();
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit st;
    void'($urandom(32'd7741));
    @(negedge clk_i);
    do_reset();

    // R1 reset state
    chk_all("R1");
    check("R1 status", exp_status(), 32'h1);

    // R2 decode and registered read timing
    rd_chk("R2", 9'h004);
    rd_chk("R2", 9'h141);
    rd_chk("R2", 9'h1FC);
    rd_chk("R2 seed readback", 9'h140);
    bus_rd(9'h010, v);
    check("R2 read", v, 32'h1);
    idle(1);
    check("R2 idle", rd_data_o, 32'h0);

    // R4/R5 start refused with no seeds
    ctrl_wr(32'h18, st);
    rd_chk("R4 no seeds", 9'h010);
    rd_chk("R5", 9'h000);
    check("R5 go bit", m_ctrl, 32'h8);

    // R3 mask
    for (int i = 0; i < N-1; i++) seed_wr(i, 32'h1000 + 32'(i));
    rd_chk("R3 partial", 9'h010);
    seed_wr(N-1, 32'hCAFE0004);
    bus_rd(9'h010, v);
    check("R3 full", v, 32'h3);

    // R4 engine not selected / start missing
    ctrl_wr(32'h10, st);
    idle(6);
    chk_all("R4 no engine");
    ctrl_wr(32'h08, st);
    idle(6);
    chk_all("R4 no start");

    // R6 busy for exactly five cycles, then done
    ctrl_wr(32'h18, st);
    for (int i = 0; i < 5; i++) begin
      bus_rd(9'h010, v);
      check("R6 busy", v, 32'h7);
    end
    model_run();
    bus_rd(9'h010, v);
    check("R6 done", v, 32'h23);
    chk_all("R8 run1");

    // R7 status writes
    bus_wr(9'h010, 32'hFFFF_FFFF);
    m_flags = 3'b111;
    bus_rd(9'h010, v);
    check("R7 set", v, 32'h3B);
    bus_wr(9'h010, 32'h0);
    m_flags = 3'b000;
    bus_rd(9'h010, v);
    check("R7 clear", v, 32'h3);

    // R6 control write with start during a run is stored, no second run
    ctrl_wr(32'h18, st);
    ctrl_wr(32'h38, st);
    for (int i = 0; i < 4; i++) begin
      bus_rd(9'h010, v);
      check("R6 busy2", v, 32'h7);
    end
    model_run();
    bus_rd(9'h010, v);
    check("R6 single run", v, 32'h23);
    chk_all("R6 ctrl stored");

    // R7 status clear on the completion edge: done still set
    bus_wr(9'h010, 32'h0);
    m_flags = '0;
    ctrl_wr(32'h18, st);
    idle(4);
    bus_wr(9'h010, 32'h0);
    model_run();
    bus_rd(9'h010, v);
    check("R7 priority", v, 32'h23);

    // R8 seed write during a run is dropped
    ctrl_wr(32'h18, st);
    bus_wr(9'h148, 32'hDEADBEEF);
    idle(4);
    model_run();
    ctrl_wr(32'h18, st);
    idle(5);
    model_run();
    chk_all("R8 seed dropped");

    // R10 unmapped and output-word writes
    bus_wr(9'h020, 32'hFFFFFFFF);
    bus_wr(9'h1FC, 32'hFFFFFFFF);
    bus_wr(9'h142, 32'hFFFFFFFF);
    bus_wr(9'h160, 32'h12345678);
    bus_wr(9'h003, 32'hFFFFFFFF);
    chk_all("R10");

    // R9 all-zero seeds use the fill constant
    do_reset();
    for (int i = 0; i < N; i++) seed_wr(i, 32'h0);
    ctrl_wr(32'h18, st);
    idle(5);
    model_run();
    chk_all("R9 fill");
    check("R9 word0 nonzero", (m_out[0] != 0) ? 32'h1 : 32'h0, 32'h1);

    // random mix
    do_reset();
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: seed_wr($urandom_range(0, N-1), $urandom());
        1: begin
          logic [31:0] d;
          d = $urandom();
          if ($urandom_range(0, 1) == 1) d[4:3] = 2'b11;
          ctrl_wr(d, st);
          if (st) begin idle(5); model_run(); end
        end
        2: begin
          logic [31:0] d;
          d = $urandom();
          bus_wr(9'h010, d);
          m_flags = d[5:3];
        end
        3: rd_chk("R2 rand", 9'($urandom()));
        4: rd_chk("R8 rand", 9'h160 + 9'(4 * $urandom_range(0, N-1)));
        default: begin
          logic [8:0] a;
          a = 9'($urandom());
          if (a != 9'h000 && a != 9'h010 && !(a[1:0] == 0 && a >= 9'h140 && a < 9'h154))
            bus_wr(a, $urandom());
          rd_chk("R10 rand", 9'h010);
        end
      endcase
    end
    chk_all("R8 final");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule